// File: doc/BRIEF.md
# Coprocessor Instruction Gating Controller

This block stands between the instruction decoder and an external floating-point coprocessor. For each instruction the decoder offers, it decides one of four things. The instruction may be passed to the coprocessor. It may be held while the coprocessor reports itself busy. It may be turned into an exception request. Or, when it is neither a coprocessor escape nor a wait, it is left alone. The decision depends on three control bits: emulate (EM), monitor (MP) and task-switched (TS). For some instructions it also depends on the coprocessor's active-low BUSY and ERROR pins.

The block also holds the control bits themselves. EM, MP and the protocol-type bit ET are written through a small control port, and only at privilege level zero. TS is set by every task switch and is cleared by a privileged clear command. ET is loaded at reset from the level on the ERROR pin. It selects between the 32-bit and the 16-bit coprocessor protocol, and that selection is driven out to the bus logic.

The decoder presents an instruction as a one-cycle strobe while the stall output is low. Every result (dispatch, exception, stall) is registered, so it appears in the cycle after the strobe.

Top module: `cop_gate`

## Requirements
- R1: An instruction is an escape when bits [7:3] of its first byte equal 11011 and its wait flag is clear. Such an escape, with EM=0, TS=0 and no pending error check, gives a one-cycle dispatch pulse. A strobe that is neither an escape nor a wait gives neither dispatch nor exception.
- R2: An escape with EM=1 gives an exception request with vector 7 and no dispatch, whatever the values of TS, BUSY and ERROR.
- R3: An escape with EM=0 and TS=1 gives an exception with vector 7 and no dispatch.
- R4: An escape with EM=0 and TS=0 that carries the check-error flag gives vector 16 when ERROR is low. Without that flag the level of ERROR is ignored and the escape is dispatched.
- R5: A wait instruction with MP=1 and TS=1 gives vector 7. With MP=0, TS has no effect on a wait.
- R6: A wait instruction (not trapped by R5) that meets BUSY low raises stall from the next cycle on. Stall stays high until the first cycle in which BUSY is high. In the cycle after that, stall is low, and an exception with vector 16 is raised if ERROR was low at that same edge. A wait that finds BUSY high checks ERROR at once in the same way. A wait never dispatches.
- R7: Dispatch and exception are pulses one cycle long, in the cycle after the deciding edge. They are never both high. The 5-bit vector is 7 or 16 whenever an exception is requested.
- R8: A task-switch pulse sets TS. The clear command clears TS only at privilege level 0. A task switch in the same cycle as a clear leaves TS set.
- R9: A control write at privilege level 0 loads EM, MP and ET from the write data bits [0], [1] and [2]. At any other privilege level the write leaves all three bits unchanged and raises no exception.
- R10: While reset is held, ET takes the value 1 if ERROR is low and 0 if ERROR is high. The protocol-select output always equals ET, with 1 meaning the 32-bit protocol.
- R11: An instruction strobe that arrives while stall is high is ignored: it gives no dispatch and no exception of its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | Instruction strobe from the decoder |
| op_byte | input | 8 | First opcode byte |
| op_is_wait | input | 1 | The offered instruction is a wait |
| op_chk_err | input | 1 | The escape must check the ERROR pin |
| busy_n | input | 1 | Coprocessor busy, active low |
| error_n | input | 1 | Coprocessor error, active low |
| task_sw | input | 1 | Task-switch pulse |
| clr_ts | input | 1 | Clear task-switched command |
| cr_wr | input | 1 | Control-bit write enable |
| cr_wdata | input | 3 | Write data: [0] EM, [1] MP, [2] ET |
| cpl | input | 2 | Current privilege level |
| em | output | 1 | Emulate bit |
| mp | output | 1 | Monitor bit |
| ts | output | 1 | Task-switched bit |
| et | output | 1 | Coprocessor type bit |
| disp | output | 1 | Dispatch pulse to the coprocessor |
| proto32 | output | 1 | 1 selects the 32-bit protocol |
| stall | output | 1 | Hold the decoder |
| exc_req | output | 1 | Exception request pulse |
| exc_vec | output | 5 | Exception vector |

## Verification
The control bits are driven straight out, so a wrong EM, MP, TS or ET value is visible on the ports in the cycle after the edge that corrupted it. It then also changes the decision for the next escape or wait. A wrong hold state shows up in one of two ways. Either stall fails to drop in the cycle after BUSY is seen high, or a strobe is acted on while stall is high; in both cases the dispatch or vector output is wrong within one cycle. The bench compares every output against a behavioural model at every clock, under directed corner cases and a long pseudo-random phase.

// File: rtl/cop_gate_pkg.sv
package cop_gate_pkg;

    localparam int          VEC_W      = 5;
    localparam int          PFX_W      = 5;
    localparam logic [4:0]  ESC_PFX    = 5'b11011;
    localparam logic [4:0]  VEC_NOCOP  = 5'd7;
    localparam logic [4:0]  VEC_COPERR = 5'd16;

    typedef enum logic {
        ST_IDLE,
        ST_HOLD
    } issue_st_e;

    typedef struct packed {
        logic em;
        logic mp;
        logic ts;
        logic et;
    } cop_ctrl_t;

    typedef struct packed {
        issue_st_e         st;
        logic              disp;
        logic              exc;
        logic [VEC_W-1:0]  vec;
    } issue_t;

endpackage

// File: rtl/cop_ctrl_regs.sv
module cop_ctrl_regs
    import cop_gate_pkg::*;
#(
    parameter int PL_W = 2,
    parameter int WD_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             error_n,
    input  logic             task_sw,
    input  logic             clr_ts,
    input  logic             cr_wr,
    input  logic [WD_W-1:0]  cr_wdata,
    input  logic [PL_W-1:0]  cpl,
    output cop_ctrl_t        ctrl
);

    localparam int BIT_EM = 0;
    localparam int BIT_MP = 1;
    localparam int BIT_ET = 2;

    cop_ctrl_t ctrl_d, ctrl_q;
    logic      priv_ok;

    assign priv_ok = (cpl == '0);

    always_comb begin
        ctrl_d = ctrl_q;
        if (cr_wr && priv_ok) begin
            ctrl_d.em = cr_wdata[BIT_EM];
            ctrl_d.mp = cr_wdata[BIT_MP];
            ctrl_d.et = cr_wdata[BIT_ET];
        end
        if (task_sw) begin
            ctrl_d.ts = 1'b1;
        end else if (clr_ts && priv_ok) begin
            ctrl_d.ts = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q.em <= 1'b0;
            ctrl_q.mp <= 1'b0;
            ctrl_q.ts <= 1'b0;
            ctrl_q.et <= ~error_n;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;

    // R9: writes from a nonzero privilege level leave the bits unchanged
    p_user_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_wr && cpl != '0) |=> (ctrl_q.em == $past(ctrl_q.em) &&
                                  ctrl_q.mp == $past(ctrl_q.mp) &&
                                  ctrl_q.et == $past(ctrl_q.et)));

    // R8: a task switch always leaves TS set
    p_ts_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        task_sw |=> ctrl_q.ts);

    // R8: a privileged clear without a task switch clears TS
    p_ts_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ts && !task_sw && cpl == '0) |=> !ctrl_q.ts);

    // R8: an unprivileged clear has no effect
    p_ts_user_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_ts && !task_sw && cpl != '0) |=> (ctrl_q.ts == $past(ctrl_q.ts)));

endmodule

// File: rtl/cop_issue.sv
module cop_issue
    import cop_gate_pkg::*;
#(
    parameter int OP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_byte,
    input  logic             op_is_wait,
    input  logic             op_chk_err,
    input  logic             busy_n,
    input  logic             error_n,
    input  cop_ctrl_t        ctrl,
    output logic             disp,
    output logic             exc,
    output logic [VEC_W-1:0] vec,
    output logic             stall
);

    issue_t issue_d, issue_q;
    logic   is_esc;
    logic   take;

    assign is_esc = (op_byte[OP_W-1 -: PFX_W] == ESC_PFX) && !op_is_wait;
    assign take   = op_valid && (issue_q.st == ST_IDLE);

    always_comb begin
        issue_d      = issue_q;
        issue_d.disp = 1'b0;
        issue_d.exc  = 1'b0;
        issue_d.vec  = '0;
        if (issue_q.st == ST_HOLD) begin
            if (busy_n) begin
                issue_d.st = ST_IDLE;
                if (!error_n) begin
                    issue_d.exc = 1'b1;
                    issue_d.vec = VEC_COPERR;
                end
            end
        end else if (take) begin
            if (op_is_wait) begin
                if (ctrl.mp && ctrl.ts) begin
                    issue_d.exc = 1'b1;
                    issue_d.vec = VEC_NOCOP;
                end else if (!busy_n) begin
                    issue_d.st = ST_HOLD;
                end else if (!error_n) begin
                    issue_d.exc = 1'b1;
                    issue_d.vec = VEC_COPERR;
                end
            end else if (is_esc) begin
                if (ctrl.em || ctrl.ts) begin
                    issue_d.exc = 1'b1;
                    issue_d.vec = VEC_NOCOP;
                end else if (op_chk_err && !error_n) begin
                    issue_d.exc = 1'b1;
                    issue_d.vec = VEC_COPERR;
                end else begin
                    issue_d.disp = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            issue_q.st   <= ST_IDLE;
            issue_q.disp <= 1'b0;
            issue_q.exc  <= 1'b0;
            issue_q.vec  <= '0;
        end else begin
            issue_q <= issue_d;
        end
    end

    assign disp  = issue_q.disp;
    assign exc   = issue_q.exc;
    assign vec   = issue_q.vec;
    assign stall = (issue_q.st == ST_HOLD);

    // R2: emulation traps an escape ahead of every other condition
    p_em_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !stall && !op_is_wait &&
         op_byte[OP_W-1 -: PFX_W] == ESC_PFX && ctrl.em)
        |=> (exc && vec == VEC_NOCOP && !disp));

    // R3: task-switched escape traps
    p_ts_esc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !stall && !op_is_wait &&
         op_byte[OP_W-1 -: PFX_W] == ESC_PFX && ctrl.ts)
        |=> (exc && vec == VEC_NOCOP));

    // R5: a monitored wait with TS set traps
    p_wait_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !stall && op_is_wait && ctrl.mp && ctrl.ts)
        |=> (exc && vec == VEC_NOCOP && !stall));

    // R6: the stall holds while BUSY stays low
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !busy_n) |=> stall);

    // R6: the stall ends one cycle after BUSY is seen high
    p_stall_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && busy_n) |=> !stall);

    // R7: dispatch and exception never coincide and the vector is legal
    p_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(disp && exc));
    p_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
        exc |-> (vec == VEC_NOCOP || vec == VEC_COPERR));

    // R11: a strobe during a stall is not dispatched
    p_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && op_valid) |=> !disp);

endmodule

// File: rtl/cop_gate.sv
module cop_gate
    import cop_gate_pkg::*;
#(
    parameter int OP_W = 8,
    parameter int PL_W = 2,
    parameter int WD_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OP_W-1:0]  op_byte,
    input  logic             op_is_wait,
    input  logic             op_chk_err,
    input  logic             busy_n,
    input  logic             error_n,
    input  logic             task_sw,
    input  logic             clr_ts,
    input  logic             cr_wr,
    input  logic [WD_W-1:0]  cr_wdata,
    input  logic [PL_W-1:0]  cpl,
    output logic             em,
    output logic             mp,
    output logic             ts,
    output logic             et,
    output logic             disp,
    output logic             proto32,
    output logic             stall,
    output logic             exc_req,
    output logic [VEC_W-1:0] exc_vec
);

    cop_ctrl_t ctrl;

    cop_ctrl_regs #(
        .PL_W (PL_W),
        .WD_W (WD_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .error_n  (error_n),
        .task_sw  (task_sw),
        .clr_ts   (clr_ts),
        .cr_wr    (cr_wr),
        .cr_wdata (cr_wdata),
        .cpl      (cpl),
        .ctrl     (ctrl)
    );

    cop_issue #(
        .OP_W (OP_W)
    ) u_issue (
        .clk        (clk),
        .rst_n      (rst_n),
        .op_valid   (op_valid),
        .op_byte    (op_byte),
        .op_is_wait (op_is_wait),
        .op_chk_err (op_chk_err),
        .busy_n     (busy_n),
        .error_n    (error_n),
        .ctrl       (ctrl),
        .disp       (disp),
        .exc        (exc_req),
        .vec        (exc_vec),
        .stall      (stall)
    );

    assign em      = ctrl.em;
    assign mp      = ctrl.mp;
    assign ts      = ctrl.ts;
    assign et      = ctrl.et;
    assign proto32 = ctrl.et;

    // R10: the protocol select follows ET
    p_proto_r10: assert property (@(posedge clk) disable iff (!rst_n)
        proto32 == et);

endmodule

// File: tb/test_cop_gate.sv
module test_cop_gate;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] op_byte = 8'h00;
    logic       op_is_wait = 1'b0;
    logic       op_chk_err = 1'b0;
    logic       busy_n = 1'b1;
    logic       error_n = 1'b1;
    logic       task_sw = 1'b0;
    logic       clr_ts = 1'b0;
    logic       cr_wr = 1'b0;
    logic [2:0] cr_wdata = 3'b000;
    logic [1:0] cpl = 2'd0;
    logic       em, mp, ts, et, disp, proto32, stall, exc_req;
    logic [4:0] exc_vec;

    always #2 clk = ~clk;

    cop_gate i_cop_gate (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_byte(op_byte),
        .op_is_wait(op_is_wait), .op_chk_err(op_chk_err), .busy_n(busy_n),
        .error_n(error_n), .task_sw(task_sw), .clr_ts(clr_ts), .cr_wr(cr_wr),
        .cr_wdata(cr_wdata), .cpl(cpl), .em(em), .mp(mp), .ts(ts), .et(et),
        .disp(disp), .proto32(proto32), .stall(stall), .exc_req(exc_req),
        .exc_vec(exc_vec)
    );

    // behavioural reference
    bit    started = 0;
    bit    m_em, m_mp, m_ts, m_et, m_stall, m_disp, m_exc;
    int    m_vec;
    string m_tag = "R7";
    int    vectors = 0;
    int    miscompares = 0;
    int    cycles = 0;

    always @(posedge clk) begin
        bit n_stall, n_disp, n_exc;
        int n_vec;
        started = 1;
        cycles++;
        if (!rst_n) begin
            m_em = 0; m_mp = 0; m_ts = 0; m_et = !error_n;
            m_stall = 0; m_disp = 0; m_exc = 0; m_vec = 0; m_tag = "R10";
        end else begin
            n_stall = m_stall; n_disp = 0; n_exc = 0; n_vec = 0;
            if (m_stall) begin
                m_tag = op_valid ? "R11" : "R6";
                if (busy_n) begin
                    n_stall = 0;
                    if (!error_n) begin n_exc = 1; n_vec = 16; end
                end
            end else if (op_valid) begin
                if (op_is_wait) begin
                    if (m_mp && m_ts) begin
                        n_exc = 1; n_vec = 7; m_tag = "R5";
                    end else if (!busy_n) begin
                        n_stall = 1; m_tag = "R6";
                    end else begin
                        m_tag = "R6";
                        if (!error_n) begin n_exc = 1; n_vec = 16; end
                    end
                end else if (op_byte[7:3] == 5'b11011) begin
                    if (m_em) begin n_exc = 1; n_vec = 7; m_tag = "R2"; end
                    else if (m_ts) begin n_exc = 1; n_vec = 7; m_tag = "R3"; end
                    else if (op_chk_err && !error_n) begin
                        n_exc = 1; n_vec = 16; m_tag = "R4";
                    end else begin
                        n_disp = 1; m_tag = op_chk_err ? "R1" : "R4";
                    end
                end else begin
                    m_tag = "R1";
                end
            end else begin
                m_tag = "R7";
            end
            if (cr_wr && cpl == 0) begin
                m_em = cr_wdata[0]; m_mp = cr_wdata[1]; m_et = cr_wdata[2];
            end
            if (task_sw) m_ts = 1;
            else if (clr_ts && cpl == 0) m_ts = 0;
            m_stall = n_stall; m_disp = n_disp; m_exc = n_exc; m_vec = n_vec;
        end
    end

    task automatic cmp(input string tag, input string name, input int act,
                       input int exp, inout bit bad);
        if (act != exp) begin
            $display("FAIL %s %s: actual %0d expected %0d at cycle %0d",
                     tag, name, act, exp, cycles);
            bad = 1;
        end
    endtask

    always @(negedge clk) begin
        bit bad;
        if (started) begin
            bad = 0;
            vectors++;
            cmp("R9",  "em",      int'(em),      int'(m_em),    bad);
            cmp("R9",  "mp",      int'(mp),      int'(m_mp),    bad);
            cmp("R8",  "ts",      int'(ts),      int'(m_ts),    bad);
            cmp("R10", "et",      int'(et),      int'(m_et),    bad);
            cmp("R10", "proto32", int'(proto32), int'(m_et),    bad);
            cmp("R6",  "stall",   int'(stall),   int'(m_stall), bad);
            cmp(m_tag, "disp",    int'(disp),    int'(m_disp),  bad);
            cmp(m_tag, "exc_req", int'(exc_req), int'(m_exc),   bad);
            cmp(m_tag, "exc_vec", int'(exc_vec), m_exc ? m_vec : int'(exc_vec), bad);
            if (bad) miscompares++;
        end
    end

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic quiet();
        op_valid = 0; op_is_wait = 0; op_chk_err = 0; op_byte = 8'h00;
        task_sw = 0; clr_ts = 0; cr_wr = 0; cr_wdata = 3'b000; cpl = 2'd0;
    endtask

    task automatic esc(input logic [7:0] b, input logic chk);
        op_valid = 1; op_byte = b; op_chk_err = chk; op_is_wait = 0;
        tick();
        quiet();
        tick();
    endtask

    task automatic wai();
        op_valid = 1; op_is_wait = 1; op_byte = 8'h9B;
        tick();
        quiet();
        tick();
    endtask

    task automatic wr(input logic [1:0] pl, input logic [2:0] d);
        cr_wr = 1; cpl = pl; cr_wdata = d;
        tick();
        quiet();
        tick();
    endtask

    task automatic report();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        #800000;
        $display("FAIL watchdog: actual running expected finished");
        miscompares++;
        report();
    end

    initial begin
        // R10: ERROR low during reset gives ET=1
        error_n = 0;
        repeat (3) @(negedge clk);
        error_n = 1;
        rst_n = 1;
        tick();
        // R1: plain escape dispatches, other bytes do nothing
        esc(8'hD9, 0);
        esc(8'hDF, 1);
        esc(8'h90, 0);
        esc(8'hE8, 0);
        // R9: unprivileged write ignored, privileged write takes effect
        wr(2'd3, 3'b111);
        wr(2'd1, 3'b011);
        wr(2'd0, 3'b001);
        // R2: EM traps even with ERROR low and check requested
        error_n = 0;
        esc(8'hD8, 1);
        error_n = 1;
        wr(2'd0, 3'b010);
        // R8 and R3: task switch sets TS; escape traps
        task_sw = 1; tick(); quiet(); tick();
        esc(8'hDD, 0);
        // R5: MP and TS set -> wait traps
        wai();
        // R8: unprivileged clear ignored; switch wins over clear
        clr_ts = 1; cpl = 2'd2; tick(); quiet(); tick();
        clr_ts = 1; task_sw = 1; tick(); quiet(); tick();
        clr_ts = 1; tick(); quiet(); tick();
        // R5: with MP clear, TS is not tested by a wait
        wr(2'd0, 3'b000);
        task_sw = 1; tick(); quiet(); tick();
        wai();
        clr_ts = 1; tick(); quiet(); tick();
        // R4: error check on escapes
        error_n = 0;
        esc(8'hD9, 1);
        esc(8'hD9, 0);
        error_n = 1;
        // R6, R11: wait stalls on BUSY, strobes ignored, then ERROR sampled
        busy_n = 0;
        op_valid = 1; op_is_wait = 1; tick();
        quiet();
        repeat (2) tick();
        op_valid = 1; op_byte = 8'hD9; tick(); quiet();
        repeat (2) tick();
        error_n = 0; busy_n = 1; tick();
        error_n = 1; tick();
        // R6: wait with BUSY high and ERROR low traps at once
        error_n = 0; wai(); error_n = 1;
        // pseudo-random phase
        for (int i = 0; i < 6000; i++) begin
            int r;
            r = $urandom_range(0, 99);
            op_valid   = (r < 45);
            op_is_wait = ($urandom_range(0, 3) == 0);
            op_byte    = ($urandom_range(0, 1) == 0) ?
                         {5'b11011, 3'($urandom_range(0, 7))} : 8'($urandom_range(0, 255));
            op_chk_err = 1'($urandom_range(0, 1));
            busy_n     = ($urandom_range(0, 9) > 3);
            error_n    = ($urandom_range(0, 9) > 2);
            task_sw    = ($urandom_range(0, 19) == 0);
            clr_ts     = ($urandom_range(0, 5) == 0);
            cr_wr      = ($urandom_range(0, 11) == 0);
            cr_wdata   = 3'($urandom_range(0, 7));
            cpl        = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(1, 3)) : 2'd0;
            tick();
        end
        quiet();
        busy_n = 1;
        // R10: ERROR high during reset gives ET=0
        rst_n = 0; error_n = 1;
        repeat (2) tick();
        rst_n = 1;
        repeat (2) tick();
        report();
    end

endmodule